// File: doc/BRIEF.md
# Lockable thermal-protection register bank

This block holds the programmable settings of an on-die thermal monitor and turns a sensor reading into a hardware shutdown request. Firmware programs a critical temperature threshold, a 32-bit calibration slope and a shutdown enable over a simple synchronous register bus. It then sets a write-once lock. From the cycle after the lock is set, those three settings are frozen until the next power-on reset.

A secondary (soft) reset strobe and a debug-unlock strobe are also wired to the block. While the bank is unlocked, either strobe returns the settings to their defaults. Once the lock is set, both strobes are refused, and the lock itself can be cleared only by the asynchronous power-on reset `rst_ni`.

The current sensor value is captured every cycle and compared with the threshold. When shutdown is enabled and the captured value reaches the threshold, a sticky shutdown request is raised. The request holds until power-on reset. Reads are combinational from the address. Writes take effect on the rising clock edge.

Top module: `thermal_guard_regs`

## Requirements
- R1: After power-on reset, the registers read as follows: threshold 125 (0x7D) at 0x00, calibration 0 at 0x04, lock 0 at 0x08, shutdown enable 0 at 0x0C and current temperature 0 at 0x10. `shutdown_o` is low.
- R2: A write to 0x00 stores `wdata_i[7:0]` as the threshold. Bits [31:8] of that register always read as zero.
- R3: A write to 0x04 stores all 32 bits of `wdata_i` as the calibration word.
- R4: A write to 0x08 with `wdata_i[0]`=1 sets the lock, which reads back in bit 0. No later write, including a write of 0, clears it.
- R5: In every cycle after the lock is set, writes to 0x00, 0x04 and 0x0C leave those registers unchanged.
- R6: The shutdown enable is bit 1 of 0x0C. A write there stores `wdata_i[1]`, and all other bits of 0x0C read as zero.
- R7: 0x10 returns the value of `temp_i` captured at the previous rising edge, zero-extended. Writes to 0x10 have no effect.
- R8: Any address other than the five listed reads as zero, and writes to it change no register.
- R9: While unlocked, a cycle with `soft_rst_i` or `dbg_unlock_i` high restores the threshold, calibration and enable defaults, and takes priority over a write in the same cycle. While locked, both inputs have no effect on any register.
- R10: `shutdown_o` rises one cycle after the captured temperature is greater than or equal to the threshold while the enable is 1. It then stays high, even if the temperature falls or a soft reset arrives.
- R11: Only a low level on `rst_ni` clears the lock and `shutdown_o`. Neither `soft_rst_i` nor `dbg_unlock_i`, held for any number of cycles, changes the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| soft_rst_i | input | 1 | Secondary reset strobe, active high |
| dbg_unlock_i | input | 1 | Debug-unlock strobe, active high |
| addr_i | input | 5 | Register byte address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| temp_i | input | 8 | Sensor temperature in degrees Celsius |
| shutdown_o | output | 1 | Sticky hardware shutdown request |

## Verification
The hardest state to reach from the ports is a locked bank that still holds non-default settings and is then hit by every bypass path: a soft-reset pulse, a debug-unlock level held over several cycles, a write of 0 to the lock, and plain writes to the protected registers. The stimulus first shows that both strobes really restore defaults while unlocked. It then reprograms distinctive values, sets the lock and runs the attacks, reading every protected register back after each one. The shutdown path is driven at the exact threshold value, then with the temperature dropped and a soft reset applied, to show the request stays sticky until power-on reset.

// File: rtl/thermal_guard_pkg.sv
`timescale 1ns/1ps
package thermal_guard_pkg;
  localparam int unsigned OFF_LIMIT = 32'h00;
  localparam int unsigned OFF_CALIB = 32'h04;
  localparam int unsigned OFF_LOCK  = 32'h08;
  localparam int unsigned OFF_SDEN  = 32'h0C;
  localparam int unsigned OFF_TEMP  = 32'h10;
  localparam int unsigned LOCK_BIT  = 0;
  localparam int unsigned SDEN_BIT  = 1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LIMIT,
    SEL_CALIB,
    SEL_LOCK,
    SEL_SDEN,
    SEL_TEMP
  } reg_sel_e;
endpackage

// File: rtl/tg_lock_cell.sv
`timescale 1ns/1ps
module tg_lock_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  output logic lock_o
);
  // only the power-on reset can clear this flop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lock_o <= 1'b0;
    else if (set_i) lock_o <= 1'b1;
  end
endmodule

// File: rtl/tg_cfg_regs.sv
`timescale 1ns/1ps
module tg_cfg_regs
  import thermal_guard_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TEMP_W = 8,
  parameter logic [TEMP_W-1:0] LIMIT_RST = TEMP_W'(125),
  parameter logic [DATA_W-1:0] CALIB_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              restore_i,
  input  logic              wr_limit_i,
  input  logic              wr_calib_i,
  input  logic              wr_sden_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [TEMP_W-1:0] limit_o,
  output logic [DATA_W-1:0] calib_o,
  output logic              sden_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      limit_o <= LIMIT_RST;
      calib_o <= CALIB_RST;
      sden_o  <= 1'b0;
    end else if (!lock_i) begin
      if (restore_i) begin
        limit_o <= LIMIT_RST;
        calib_o <= CALIB_RST;
        sden_o  <= 1'b0;
      end else begin
        if (wr_limit_i) limit_o <= wdata_i[TEMP_W-1:0];
        if (wr_calib_i) calib_o <= wdata_i;
        if (wr_sden_i)  sden_o  <= wdata_i[SDEN_BIT];
      end
    end
  end
endmodule

// File: rtl/tg_trip.sv
`timescale 1ns/1ps
module tg_trip #(
  parameter int unsigned TEMP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0] limit_i,
  input  logic              en_i,
  output logic [TEMP_W-1:0] cur_temp_o,
  output logic              shutdown_o
);
  logic hot;
  assign hot = en_i && (cur_temp_o >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_temp_o <= '0;
      shutdown_o <= 1'b0;
    end else begin
      cur_temp_o <= temp_i;
      if (hot) shutdown_o <= 1'b1;
    end
  end
endmodule

// File: rtl/thermal_guard_regs.sv
`timescale 1ns/1ps
module thermal_guard_regs
  import thermal_guard_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned TEMP_W = 8,
  parameter logic [TEMP_W-1:0] LIMIT_RST = TEMP_W'(125),
  parameter logic [DATA_W-1:0] CALIB_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              dbg_unlock_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              shutdown_o
);
  reg_sel_e          sel;
  logic              lock_q;
  logic [TEMP_W-1:0] limit_q;
  logic [DATA_W-1:0] calib_q;
  logic              sden_q;
  logic [TEMP_W-1:0] cur_temp_q;

  always_comb begin
    if      (addr_i == ADDR_W'(OFF_LIMIT)) sel = SEL_LIMIT;
    else if (addr_i == ADDR_W'(OFF_CALIB)) sel = SEL_CALIB;
    else if (addr_i == ADDR_W'(OFF_LOCK))  sel = SEL_LOCK;
    else if (addr_i == ADDR_W'(OFF_SDEN))  sel = SEL_SDEN;
    else if (addr_i == ADDR_W'(OFF_TEMP))  sel = SEL_TEMP;
    else                                   sel = SEL_NONE;
  end

  tg_lock_cell u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (we_i && (sel == SEL_LOCK) && wdata_i[LOCK_BIT]),
    .lock_o (lock_q)
  );

  // blocking keys off the registered lock: the setting cycle's write lands
  tg_cfg_regs #(
    .DATA_W    (DATA_W),
    .TEMP_W    (TEMP_W),
    .LIMIT_RST (LIMIT_RST),
    .CALIB_RST (CALIB_RST)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lock_i     (lock_q),
    .restore_i  (soft_rst_i || dbg_unlock_i),
    .wr_limit_i (we_i && (sel == SEL_LIMIT)),
    .wr_calib_i (we_i && (sel == SEL_CALIB)),
    .wr_sden_i  (we_i && (sel == SEL_SDEN)),
    .wdata_i    (wdata_i),
    .limit_o    (limit_q),
    .calib_o    (calib_q),
    .sden_o     (sden_q)
  );

  tg_trip #(.TEMP_W(TEMP_W)) u_trip (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .temp_i     (temp_i),
    .limit_i    (limit_q),
    .en_i       (sden_q),
    .cur_temp_o (cur_temp_q),
    .shutdown_o (shutdown_o)
  );

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_LIMIT: rdata_o[TEMP_W-1:0] = limit_q;
      SEL_CALIB: rdata_o             = calib_q;
      SEL_LOCK:  rdata_o[LOCK_BIT]   = lock_q;
      SEL_SDEN:  rdata_o[SDEN_BIT]   = sden_q;
      SEL_TEMP:  rdata_o[TEMP_W-1:0] = cur_temp_q;
      default:   rdata_o             = '0;
    endcase
  end
endmodule

// File: rtl/tg_checker.sv
`timescale 1ns/1ps
module tg_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned TEMP_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              lock_q,
  input logic [TEMP_W-1:0] limit_q,
  input logic [DATA_W-1:0] calib_q,
  input logic              sden_q,
  input logic              shutdown_o
);
  logic mapped;
  assign mapped = (addr_i == ADDR_W'(32'h00)) || (addr_i == ADDR_W'(32'h04)) ||
                  (addr_i == ADDR_W'(32'h08)) || (addr_i == ADDR_W'(32'h0C)) ||
                  (addr_i == ADDR_W'(32'h10));

  // R4
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);
  // R5
  limit_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(limit_q));
  // R5
  calib_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(calib_q));
  // R5
  sden_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(sden_q));
  // R10
  shutdown_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |=> shutdown_o);
  // R2
  limit_reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(32'h00)) |-> (rdata_o[DATA_W-1:TEMP_W] == '0));
  // R8
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> (rdata_o == '0));
endmodule

bind thermal_guard_regs tg_checker #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .TEMP_W (TEMP_W)
) u_tg_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .lock_q     (lock_q),
  .limit_q    (limit_q),
  .calib_q    (calib_q),
  .sden_q     (sden_q),
  .shutdown_o (shutdown_o)
);

// File: tb/thermal_guard_regs_bench.sv
`timescale 1ns/1ps
module thermal_guard_regs_bench;
  localparam int DW = 32;
  localparam int AW = 5;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          soft_rst_i = 1'b0;
  logic          dbg_unlock_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          we_i = 1'b0;
  logic [DW-1:0] wdata_i = '0;
  logic [TW-1:0] temp_i = '0;
  logic [DW-1:0] rdata_o;
  logic          shutdown_o;

  always #5 clk = ~clk;

  thermal_guard_regs u_thermal_guard_regs (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .soft_rst_i   (soft_rst_i),
    .dbg_unlock_i (dbg_unlock_i),
    .addr_i       (addr_i),
    .we_i         (we_i),
    .wdata_i      (wdata_i),
    .rdata_o      (rdata_o),
    .temp_i       (temp_i),
    .shutdown_o   (shutdown_o)
  );

  // scoreboard: expected value, kind (0 = read data, 1 = shutdown), tag
  logic [DW-1:0] exp_q[$];
  int            kind_q[$];
  string         tag_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit reported = 1'b0;

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
  endtask

  // monitor: compare mid low phase, after the driver has settled inputs
  initial forever begin
    @(negedge clk);
    #3;
    while (exp_q.size() > 0) begin
      logic [DW-1:0] e;
      logic [DW-1:0] a;
      int k;
      string t;
      e = exp_q.pop_front();
      k = kind_q.pop_front();
      t = tag_q.pop_front();
      a = (k == 1) ? {{(DW-1){1'b0}}, shutdown_o} : rdata_o;
      n_chk++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s actual=0x%08h expected=0x%08h", t, a, e);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
    @(negedge clk);
    addr_i = a; we_i = 1'b0;
    exp_q.push_back(e); kind_q.push_back(0); tag_q.push_back(t);
  endtask

  task automatic sd(input logic e, input string t);
    @(negedge clk);
    exp_q.push_back({{(DW-1){1'b0}}, e}); kind_q.push_back(1); tag_q.push_back(t);
  endtask

  task automatic pulse_soft(input int n);
    @(negedge clk); soft_rst_i = 1'b1;
    repeat (n) @(negedge clk);
    soft_rst_i = 1'b0;
  endtask

  task automatic pulse_dbg(input int n);
    @(negedge clk); dbg_unlock_i = 1'b1;
    repeat (n) @(negedge clk);
    dbg_unlock_i = 1'b0;
  endtask

  task automatic set_temp(input logic [TW-1:0] v);
    @(negedge clk); temp_i = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    rd(5'h00, 32'h7D, "R1 limit");
    rd(5'h04, 32'h0,  "R1 calib");
    rd(5'h08, 32'h0,  "R1 lock");
    rd(5'h0C, 32'h0,  "R1 sden");
    rd(5'h10, 32'h0,  "R1 temp");
    sd(1'b0, "R1 shutdown");
    // R2 R3 R6 R7 R8
    wr(5'h00, 32'hFFFF_FF50); rd(5'h00, 32'h50, "R2 limit low byte only");
    wr(5'h04, 32'hDEAD_BEEF); rd(5'h04, 32'hDEAD_BEEF, "R3 calib");
    wr(5'h0C, 32'hFFFF_FFFF); rd(5'h0C, 32'h2, "R6 sden bit1 only");
    wr(5'h10, 32'h55);        rd(5'h10, 32'h0, "R7 temp read-only");
    wr(5'h14, 32'hFFFF_FFFF); rd(5'h14, 32'h0, "R8 unmapped read");
    rd(5'h1C, 32'h0, "R8 unmapped read");
    rd(5'h00, 32'h50, "R8 unmapped write kept limit");
    rd(5'h04, 32'hDEAD_BEEF, "R8 unmapped write kept calib");
    // R9 strobes restore defaults while unlocked
    pulse_soft(1);
    rd(5'h00, 32'h7D, "R9 soft limit");
    rd(5'h04, 32'h0,  "R9 soft calib");
    rd(5'h0C, 32'h0,  "R9 soft sden");
    wr(5'h00, 32'h60); wr(5'h04, 32'h1234_5678); wr(5'h0C, 32'h2);
    pulse_dbg(1);
    rd(5'h00, 32'h7D, "R9 dbg limit");
    rd(5'h04, 32'h0,  "R9 dbg calib");
    rd(5'h0C, 32'h0,  "R9 dbg sden");
    // R9 strobe wins over a same-cycle write
    @(negedge clk);
    addr_i = 5'h00; wdata_i = 32'h33; we_i = 1'b1; soft_rst_i = 1'b1;
    @(negedge clk);
    we_i = 1'b0; soft_rst_i = 1'b0;
    rd(5'h00, 32'h7D, "R9 strobe over write");
    wr(5'h00, 32'h60); wr(5'h04, 32'hCAFE_F00D); wr(5'h0C, 32'h2);
    // below threshold
    set_temp(8'h50);
    rd(5'h10, 32'h50, "R7 temp capture");
    sd(1'b0, "R10 below limit");
    // R4 lock
    wr(5'h08, 32'h1); rd(5'h08, 32'h1, "R4 lock set");
    wr(5'h08, 32'h0); rd(5'h08, 32'h1, "R4 write0 keeps lock");
    // R5 locked writes
    wr(5'h00, 32'h10); wr(5'h04, 32'h0); wr(5'h0C, 32'h0);
    rd(5'h00, 32'h60, "R5 limit frozen");
    rd(5'h04, 32'hCAFE_F00D, "R5 calib frozen");
    rd(5'h0C, 32'h2, "R5 sden frozen");
    // R9 R11 bypass attempts
    pulse_soft(1);
    pulse_dbg(4);
    rd(5'h08, 32'h1, "R11 lock after strobes");
    rd(5'h00, 32'h60, "R9 locked limit");
    rd(5'h04, 32'hCAFE_F00D, "R9 locked calib");
    rd(5'h0C, 32'h2, "R9 locked sden");
    // R10 trip at exact threshold
    set_temp(8'h60);
    rd(5'h10, 32'h60, "R7 temp capture");
    sd(1'b1, "R10 trip at limit");
    set_temp(8'h00);
    pulse_soft(1);
    sd(1'b1, "R10 sticky");
    // R11 power-on reset clears
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    rd(5'h08, 32'h0, "R11 lock cleared by por");
    rd(5'h00, 32'h7D, "R11 limit after por");
    sd(1'b0, "R11 shutdown cleared");
    @(negedge clk);
    #4;
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      report();
      $finish;
    end
  end
endmodule